// File: doc/BRIEF.md
# Predicated Vector Integer Compare Unit

This unit compares two packed integer vectors lane by lane under a governing mask. It writes a predicate that holds one bit per vector byte, and it produces four condition flags that summarise that predicate. The lane width is chosen per operation by a 2-bit size code and can be 8, 16, 32 or 64 bits. The comparison is chosen by a 6-bit selector that carries a few instruction bits. The vector width `VL` is a parameter and must be a multiple of 64.

Operands are accepted in any cycle where `in_valid` is high. The predicate and flags are registered and appear one clock later with `out_valid` high. A small two-state controller runs the handshake:

- `ST_IDLE` moves to `ST_RESULT` on *accept* (`in_valid` high).
- `ST_RESULT` stays in `ST_RESULT` on *accept*.
- `ST_RESULT` returns to `ST_IDLE` on *drain* (`in_valid` low).
- Reset forces `ST_IDLE`.

Less-than, lower, lower-or-same and less-or-equal are not separate operations. The caller swaps the operands and selects GT, HI, HS or GE.

Top module: `vcmp_pred_unit`

## Requirements
- R1: Size code s gives a lane width of 8<<s bits, and each lane owns a field of (8<<s)/8 predicate bits. The lane count is VL/(8<<s). With every mask bit set and EQ on equal operands, the predicate equals the repeating pattern of one 1 followed by (field width − 1) zeros, starting at bit 0.
- R2: The comparison is decoded from selector bits sel[5], sel[3] and sel[2]:
  - sel[5]=0, sel[2]=1 gives unsigned higher (HI); sel[5]=0, sel[2]=0 gives unsigned higher-or-same (HS).
  - sel[5]=1 and sel[3]=1 gives EQ when sel[2]=0 and NE when sel[2]=1.
  - sel[5]=1 and sel[3]=0 gives signed GT when sel[2]=1 and signed GE when sel[2]=0.
- R3: Signed comparisons treat each lane as two's complement at the lane width. Unsigned comparisons treat lanes as zero-extended. No comparison uses bits outside its own lane.
- R4: A lane is active when the mask bit at the lowest position of its field is 1. Other mask bits in the field have no effect. An active lane writes its compare result into the lowest bit of its predicate field.
- R5: Every predicate bit above the lowest bit of a field is 0. Every bit of an inactive lane's field is 0.
- R6: N equals the result of the lowest-numbered active lane.
- R7: Z is 1 exactly when no active lane has a true result, that is, when the predicate is all zeros.
- R8: C equals the inverse of the result of the highest-numbered active lane.
- R9: V is always 0.
- R10: When no lane is active, the predicate is all zeros and the flags are N=0, Z=1, C=1, V=0.
- R11: Inputs are sampled on a rising edge where `in_valid` is 1. The results appear after that edge with `out_valid`=1. After an edge with `in_valid`=0, `out_valid` is 0 and the predicate and flags keep their values.
- R12: A synchronous active-high reset clears the predicate, all four flags and `out_valid`.
- R13: Selector bits sel[4], sel[1] and sel[0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| opnd_a | input | VL | First operand vector; lane e occupies bits e*W upward |
| opnd_b | input | VL | Second operand vector |
| gov_pred | input | VL/8 | Governing mask, one bit per byte |
| esz_code | input | 2 | Lane size code (8, 16, 32 or 64 bits) |
| insn_sel | input | 6 | Comparison selector bits |
| out_valid | output | 1 | Result registers hold a fresh result |
| pred_out | output | VL/8 | Destination predicate, one bit per byte |
| flag_n | output | 1 | Result of the first active lane |
| flag_z | output | 1 | No active lane true |
| flag_c | output | 1 | Inverse of the result of the last active lane |
| flag_v | output | 1 | Always zero |

## Verification
Random operands are biased so that many bytes are equal between the two vectors. This makes the equality, not-equal and or-equal operations take both outcomes, and it exposes a lane that compares only some of its bytes. Extreme operands (all-ones against the signed minimum, the signed maximum against the signed minimum) tell signed ordering apart from unsigned ordering at every lane width. An all-zero mask, a single active lane, and a mask with every byte set separate the first/last flag logic and the lead-bit activity rule from a plain per-byte mask. The ignored selector bits and an idle cycle after a result are checked against the values the outputs must keep.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    typedef enum logic [2:0] {
        OP_EQ,
        OP_NE,
        OP_GT,
        OP_GE,
        OP_HI,
        OP_HS
    } cmp_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } unit_state_e;

    localparam int SEL_W      = 6;
    localparam int SEL_SIGNED = 5;
    localparam int SEL_EQFAM  = 3;
    localparam int SEL_STRICT = 2;
    localparam int NUM_SIZES  = 4;

endpackage

// File: rtl/vcmp_sel_decode.sv
module vcmp_sel_decode
    import vcmp_pkg::*;
(
    input  logic    signed_fam,
    input  logic    eq_fam,
    input  logic    strict,
    output cmp_op_e op
);
    always_comb begin
        if (!signed_fam) begin
            op = strict ? OP_HI : OP_HS;
        end else if (eq_fam) begin
            op = strict ? OP_NE : OP_EQ;
        end else begin
            op = strict ? OP_GT : OP_GE;
        end
    end
endmodule

// File: rtl/vcmp_lane_cmp.sv
module vcmp_lane_cmp
    import vcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  cmp_op_e      op,
    output logic         hit
);
    always_comb begin
        unique case (op)
            OP_EQ:   hit = (a == b);
            OP_NE:   hit = (a != b);
            OP_GT:   hit = ($signed(a) >  $signed(b));
            OP_GE:   hit = ($signed(a) >= $signed(b));
            OP_HI:   hit = (a >  b);
            OP_HS:   hit = (a >= b);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vcmp_pred_flags.sv
module vcmp_pred_flags #(
    parameter int PL = 32
) (
    input  logic [PL-1:0] act,
    input  logic [PL-1:0] res,
    output logic          n_flag,
    output logic          z_flag,
    output logic          c_flag
);
    always_comb begin
        logic found;
        found  = 1'b0;
        n_flag = 1'b0;
        c_flag = 1'b1;
        for (int i = 0; i < PL; i++) begin
            if (act[i]) begin
                if (!found) begin
                    n_flag = res[i];
                end
                found  = 1'b1;
                c_flag = ~res[i];
            end
        end
        z_flag = ~|res;
    end
endmodule

// File: rtl/vcmp_pred_unit.sv
module vcmp_pred_unit
    import vcmp_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VL-1:0]     opnd_a,
    input  logic [VL-1:0]     opnd_b,
    input  logic [VL/8-1:0]   gov_pred,
    input  logic [1:0]        esz_code,
    input  logic [SEL_W-1:0]  insn_sel,
    output logic              out_valid,
    output logic [VL/8-1:0]   pred_out,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);
    localparam int PL = VL / 8;

    unit_state_e state_q, state_d;
    cmp_op_e     op_sel;
    logic [PL-1:0] res_sz [NUM_SIZES];
    logic [PL-1:0] act_sz [NUM_SIZES];
    logic [PL-1:0] res_sel, act_sel;
    logic          n_d, z_d, c_d;
    logic          unused_sel_bits;

    assign unused_sel_bits = ^{insn_sel[4], insn_sel[1:0]};

    vcmp_sel_decode u_dec (
        .signed_fam (insn_sel[SEL_SIGNED]),
        .eq_fam     (insn_sel[SEL_EQFAM]),
        .strict     (insn_sel[SEL_STRICT]),
        .op         (op_sel)
    );

    // One comparator bank per lane size, each mapped onto the byte layout.
    for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
        localparam int EW = 8 << gs;
        localparam int EB = EW / 8;
        localparam int NL = VL / EW;
        logic [NL-1:0] hit;
        logic [PL-1:0] rs;
        logic [PL-1:0] as_l;

        for (genvar e = 0; e < NL; e++) begin : g_lane
            vcmp_lane_cmp #(.W(EW)) u_cmp (
                .a   (opnd_a[e*EW +: EW]),
                .b   (opnd_b[e*EW +: EW]),
                .op  (op_sel),
                .hit (hit[e])
            );
        end

        for (genvar i = 0; i < PL; i++) begin : g_byte
            if (i % EB == 0) begin : g_lead
                assign as_l[i] = gov_pred[i];
                assign rs[i]   = gov_pred[i] & hit[i/EB];
            end else begin : g_fill
                assign as_l[i] = 1'b0;
                assign rs[i]   = 1'b0;
            end
        end

        assign res_sz[gs] = rs;
        assign act_sz[gs] = as_l;
    end

    assign res_sel = res_sz[esz_code];
    assign act_sel = act_sz[esz_code];

    vcmp_pred_flags #(.PL(PL)) u_flags (
        .act    (act_sel),
        .res    (res_sel),
        .n_flag (n_d),
        .z_flag (z_d),
        .c_flag (c_d)
    );

    // Next-state logic: accept / drain.
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers: loaded on accept, held otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            pred_out <= '0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            flag_c   <= 1'b0;
            flag_v   <= 1'b0;
        end else if (in_valid) begin
            pred_out <= res_sel;
            flag_n   <= n_d;
            flag_z   <= z_d;
            flag_c   <= c_d;
            flag_v   <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/vcmp_pred_chk.sv
module vcmp_pred_chk #(
    parameter int VL = 256
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [VL/8-1:0] gov_pred,
    input logic [1:0]      esz_code,
    input logic            out_valid,
    input logic [VL/8-1:0] pred_out,
    input logic            flag_n,
    input logic            flag_z,
    input logic            flag_c
);
    localparam int PL = VL / 8;

    logic [1:0]    esz_q;
    logic [PL-1:0] gov_q;
    logic [PL-1:0] hi_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            esz_q <= '0;
            gov_q <= '0;
        end else if (in_valid) begin
            esz_q <= esz_code;
            gov_q <= gov_pred;
        end
    end

    always_comb begin
        for (int i = 0; i < PL; i++) begin
            hi_mask[i] = ((i % (1 << esz_q)) != 0);
        end
    end

    a_r11_accept_gives_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_drain_drops_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r5_inactive_bits_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((pred_out & ~gov_q) == '0));

    a_r5_upper_field_bits_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((pred_out & hi_mask) == '0));

    a_r7_zero_flag_matches_pred: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_z == (pred_out == '0)));

    a_r10_empty_pred_flags: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pred_out == '0) |-> (!flag_n && flag_c));

endmodule

bind vcmp_pred_unit vcmp_pred_chk #(.VL(VL)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .gov_pred  (gov_pred),
    .esz_code  (esz_code),
    .out_valid (out_valid),
    .pred_out  (pred_out),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c)
);

// File: tb/vcmp_pred_unit_tb_top.sv
`timescale 1ns/1ps
module vcmp_pred_unit_tb_top;
    localparam int VL = 256;
    localparam int PL = VL / 8;

    localparam logic [5:0] S_EQ = 6'b101000;
    localparam logic [5:0] S_NE = 6'b101100;
    localparam logic [5:0] S_GT = 6'b100100;
    localparam logic [5:0] S_GE = 6'b100000;
    localparam logic [5:0] S_HI = 6'b000100;
    localparam logic [5:0] S_HS = 6'b000000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VL-1:0] opnd_a = '0;
    logic [VL-1:0] opnd_b = '0;
    logic [PL-1:0] gov_pred = '0;
    logic [1:0]    esz_code = '0;
    logic [5:0]    insn_sel = '0;
    logic          out_valid;
    logic [PL-1:0] pred_out;
    logic          flag_n, flag_z, flag_c, flag_v;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    vcmp_pred_unit #(.VL(VL)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .gov_pred(gov_pred),
        .esz_code(esz_code), .insn_sel(insn_sel),
        .out_valid(out_valid), .pred_out(pred_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk_vec(input string tag, input logic [PL-1:0] act, input logic [PL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: pred actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] get_lane(input logic [VL-1:0] v, input int e, input int ew, input bit sx);
        logic [63:0] x;
        x = '0;
        for (int k = 0; k < ew; k++) x[k] = v[e*ew + k];
        if (sx && ew < 64 && x[ew-1]) begin
            for (int k = ew; k < 64; k++) x[k] = 1'b1;
        end
        return x;
    endfunction

    function automatic logic lane_cmp(input logic [63:0] x, input logic [63:0] y, input logic [5:0] sel);
        if (!sel[5]) return sel[2] ? (x > y) : (x >= y);
        if (sel[3])  return sel[2] ? (x != y) : (x == y);
        return sel[2] ? ($signed(x) > $signed(y)) : ($signed(x) >= $signed(y));
    endfunction

    task automatic ref_model(input logic [VL-1:0] a, input logic [VL-1:0] b,
                             input logic [PL-1:0] g, input logic [1:0] esz, input logic [5:0] sel,
                             output logic [PL-1:0] p, output logic n, output logic z, output logic c);
        int  ew;
        int  eb;
        bit  sx;
        bit  any;
        logic last, r;
        ew = 8 << esz;
        eb = ew / 8;
        sx = sel[5] && !sel[3];
        any = 0; last = 0; p = '0; n = 0;
        for (int e = 0; e < VL/ew; e++) begin
            if (g[e*eb]) begin
                r = lane_cmp(get_lane(a, e, ew, sx), get_lane(b, e, ew, sx), sel);
                p[e*eb] = r;
                if (!any) n = r;
                any = 1;
                last = r;
            end
        end
        z = (p == '0);
        c = any ? ~last : 1'b1;
    endtask

    task automatic apply(input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [PL-1:0] g,
                         input logic [1:0] esz, input logic [5:0] sel, input string tag);
        logic [PL-1:0] ep;
        logic en, ez, ec;
        @(negedge clk);
        opnd_a = a; opnd_b = b; gov_pred = g; esz_code = esz; insn_sel = sel; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        ref_model(a, b, g, esz, sel, ep, en, ez, ec);
        chk_bit("R11 out_valid", out_valid, 1'b1);
        chk_vec(tag, pred_out, ep);
        chk_bit("R6 N", flag_n, en);
        chk_bit("R7 Z", flag_z, ez);
        chk_bit("R8 C", flag_c, ec);
        chk_bit("R9 V", flag_v, 1'b0);
    endtask

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int k = 0; k < VL/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [5:0] pick_sel(input int k);
        case (k % 6)
            0: return S_EQ;
            1: return S_NE;
            2: return S_GT;
            3: return S_GE;
            4: return S_HI;
            default: return S_HS;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [VL-1:0] a, b, mn, mx;
        logic [PL-1:0] pat, held;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        // R12: reset state
        chk_bit("R12 out_valid", out_valid, 1'b0);
        chk_vec("R12 pred", pred_out, '0);
        chk_bit("R12 N", flag_n, 1'b0);
        chk_bit("R12 Z", flag_z, 1'b0);
        chk_bit("R12 C", flag_c, 1'b0);
        chk_bit("R12 V", flag_v, 1'b0);
        rst = 1'b0;

        // R1: field layout per size
        a = rand_vec();
        for (int s = 0; s < 4; s++) begin
            apply(a, a, '1, 2'(s), S_EQ, "R1 model");
            pat = '0;
            for (int i = 0; i < PL; i += (1 << s)) pat[i] = 1'b1;
            chk_vec("R1 layout", pred_out, pat);
        end

        // R10: no active lanes, every size and op
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 6; k++) begin
                apply(rand_vec(), rand_vec(), '0, 2'(s), pick_sel(k), "R10 empty");
                chk_vec("R10 pred zero", pred_out, '0);
                chk_bit("R10 Z", flag_z, 1'b1);
                chk_bit("R10 C", flag_c, 1'b1);
            end
        end

        // R3: extreme values, signed vs unsigned
        mn = '0; mx = '0;
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < VL/(8<<s); e++) begin
                mn = '0; mx = '1;
                for (int k = 0; k < VL/(8<<s); k++) begin
                    mn[k*(8<<s) + (8<<s) - 1] = 1'b1;
                    mx[k*(8<<s) + (8<<s) - 1] = 1'b0;
                end
            end
            for (int k = 0; k < 6; k++) begin
                apply('1, mn, '1, 2'(s), pick_sel(k), "R3 ones vs min");
                apply(mx, mn, '1, 2'(s), pick_sel(k), "R3 max vs min");
                apply(mn, mx, '1, 2'(s), pick_sel(k), "R3 min vs max");
                apply('0, '1, '1, 2'(s), pick_sel(k), "R3 zero vs ones");
            end
        end

        // R4: single active lane, plus non-lead mask bits only
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < VL/(8<<s); e += 3) begin
                pat = '0;
                pat[e*(1<<s)] = 1'b1;
                apply(rand_vec(), rand_vec(), pat, 2'(s), pick_sel(e + s), "R4 single lane");
            end
            if (s > 0) begin
                pat = '1;
                for (int i = 0; i < PL; i += (1 << s)) pat[i] = 1'b0;
                apply(rand_vec(), rand_vec(), pat, 2'(s), S_HS, "R4 lead bit only");
                chk_vec("R4 non-lead ignored", pred_out, '0);
            end
        end

        // R5: full mask on wide lanes
        apply(rand_vec(), rand_vec(), '1, 2'd3, S_NE, "R5 full mask");
        apply(rand_vec(), rand_vec(), '1, 2'd2, S_GE, "R5 full mask");

        // R11: idle cycle holds values and drops valid
        apply(rand_vec(), rand_vec(), '1, 2'd0, S_HI, "R11 pre-idle");
        held = pred_out;
        @(negedge clk);
        chk_bit("R11 idle valid", out_valid, 1'b0);
        chk_vec("R11 idle hold", pred_out, held);

        // R13: ignored selector bits
        for (int k = 0; k < 12; k++) begin
            a = rand_vec();
            b = a ^ {VL/32{32'h00FF0000}};
            apply(a, b, rand_vec()[PL-1:0], 2'(k % 4), pick_sel(k) | 6'b010011, "R13 ignored bits");
        end

        // R2: random mix with byte-equality bias
        for (int it = 0; it < 600; it++) begin
            logic [VL-1:0] m;
            a = rand_vec();
            m = rand_vec() & rand_vec() & rand_vec();
            b = (it % 4 == 0) ? a : (a ^ (rand_vec() & m));
            apply(a, b, rand_vec()[PL-1:0], 2'($urandom % 4),
                  pick_sel(int'($urandom % 6)) | (6'($urandom) & 6'b010011), "R2 random");
        end

        // R12: reset after a result
        apply(rand_vec(), rand_vec(), '1, 2'd0, S_HS, "R12 pre-reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_bit("R12 valid after reset", out_valid, 1'b0);
        chk_vec("R12 pred after reset", pred_out, '0);
        chk_bit("R12 Z after reset", flag_z, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule